// File: doc/BRIEF.md
# Segmented Row-Column DAC Switch Decoder

This block turns a 10-bit successive-approximation control word into the switch controls of a segmented capacitor DAC. The upper 7 bits (the coarse value `v`) pick how many of 128 unit cells are switched. These cells sit in an array of 8 rows by 16 columns. Separate row and column thermometer decoders produce the row and column selects, and a per-cell gate combines them. The lower 3 bits pass straight through as the drive for a small binary-weighted sub-array.

The SAR arithmetic produces two candidate words for the next step: one for an upward step and one for a downward step. The decoder captures both into a hold stage when `cand_ld` is pulsed. From then on both candidates are decoded in parallel, and the decoder inputs stay still while the arithmetic in front of the block keeps changing. When the comparator fires, its decision only selects which of the two finished patterns the output register stores. No decoding happens on that path. The candidate and comparator pins are plain control pins with no valid/ready handshake: the caller owns the sequencing, and the block never applies back-pressure.

Top module: `seg_dac_decoder`

## Requirements
- R1: After reset, every output (`row_full`, `row_act`, `col_sel`, `cell_en`, `bin_sel`) is all zeros until the first comparator event.
- R2: On a clock edge with `cand_ld` high, both candidate words are captured. With `cand_ld` low, changes on `cand_up`/`cand_dn` have no effect on any later output.
- R3: On a clock edge with `cmp_fire` high, the outputs take the decoded pattern of the held up word if `cmp_up` is 1, or of the held down word if `cmp_up` is 0. The outputs are valid after that same edge.
- R4: On clock edges with `cmp_fire` low, all outputs keep their values, even if a new candidate pair is loaded.
- R5: `bin_sel` equals bits [2:0] of the selected word.
- R6: With `v` = word[9:3], the column count is `v[3:0]`. `col_sel[c]` is 1 exactly when `c < v[3:0]`.
- R7: The active row is `v[6:4]`. `row_full[r]` is 1 exactly when `r < v[6:4]`, and `row_act` is one-hot at bit `v[6:4]`.
- R8: Cell `r*16+c` of `cell_en` is on when `row_full[r]` is set, or when `row_act[r]` and `col_sel[c]` are both set. The number of cells on equals `v`.
- R9: `cell_en` equals `2^v - 1` when read as a flat vector, so raising `v` by one turns on exactly cell `v` and turns off none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_up | input | 10 | Candidate control word for an upward step |
| cand_dn | input | 10 | Candidate control word for a downward step |
| cand_ld | input | 1 | Capture both candidates into the hold stage |
| cmp_fire | input | 1 | Comparator event: register the chosen pattern |
| cmp_up | input | 1 | Comparator decision, 1 selects the up candidate |
| row_full | output | 8 | Thermometer of completely filled rows |
| row_act | output | 8 | One-hot active (partially filled) row |
| col_sel | output | 16 | Column thermometer for the active row |
| cell_en | output | 128 | Per-cell switch enables, index row*16+column |
| bin_sel | output | 3 | Binary sub-array drive bits |

## Verification
The bench goes after the row borders, where `v` moves from 15 to 16 or from 111 to 112. A decoder with an off-by-one row compare would light a whole extra row there or leave a gap, and the cell count would jump by 16 or stall. The bench also targets the two ends of the range, 0 and 127, where a thermometer that is inclusive instead of strict lights one cell too many. It changes the candidates while `cand_ld` is low, and loads a fresh pair without firing. A transparent hold stage or an output that does not wait for the comparator would show the newer word. Every code is swept in both decision polarities, with a check that no cell turns off between successive values, which catches a swapped mux select or a broken row/column split.

// File: rtl/dacdec_pkg.sv
package dacdec_pkg;
  localparam int DEF_WORD_W = 10;
  localparam int DEF_LSB_W  = 3;
  localparam int DEF_ROWS   = 8;
  localparam int DEF_COLS   = 16;
endpackage

// File: rtl/dacdec_hold.sv
module dacdec_hold #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [WORD_W-1:0] up_i,
  input  logic [WORD_W-1:0] dn_i,
  output logic [WORD_W-1:0] up_q,
  output logic [WORD_W-1:0] dn_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q <= '0;
      dn_q <= '0;
    end else if (ld_i) begin
      up_q <= up_i;
      dn_q <= dn_i;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> ($stable(up_q) && $stable(dn_q))); // R2
endmodule

// File: rtl/dacdec_therm.sv
module dacdec_therm #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [N-1:0]     thm_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign thm_o[i] = (idx_i > IDX_W'(i));
  end
endmodule

// File: rtl/dacdec_onehot.sv
module dacdec_onehot #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [N-1:0]     hot_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign hot_o[i] = (idx_i == IDX_W'(i));
  end
endmodule

// File: rtl/dacdec_cells.sv
module dacdec_cells #(
  parameter int ROWS = 8,
  parameter int COLS = 16
) (
  input  logic [ROWS-1:0]      row_full_i,
  input  logic [ROWS-1:0]      row_act_i,
  input  logic [COLS-1:0]      col_thm_i,
  output logic [ROWS*COLS-1:0] cell_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign cell_o[r*COLS+c] = row_full_i[r] | (row_act_i[r] & col_thm_i[c]);
    end
  end
endmodule

// File: rtl/dacdec_path.sv
module dacdec_path #(
  parameter int WORD_W = 10,
  parameter int LSB_W  = 3,
  parameter int ROWS   = 8,
  parameter int COLS   = 16,
  localparam int MSB_W    = WORD_W - LSB_W,
  localparam int COL_BITS = $clog2(COLS),
  localparam int ROW_BITS = MSB_W - COL_BITS,
  localparam int CELLS    = ROWS * COLS
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [ROWS-1:0]   row_full_o,
  output logic [ROWS-1:0]   row_act_o,
  output logic [COLS-1:0]   col_thm_o,
  output logic [CELLS-1:0]  cell_o,
  output logic [LSB_W-1:0]  bin_o
);
  logic [MSB_W-1:0]    coarse;
  logic [COL_BITS-1:0] col_idx;
  logic [ROW_BITS-1:0] row_idx;

  assign coarse  = word_i[WORD_W-1:LSB_W];
  assign col_idx = coarse[COL_BITS-1:0];
  assign row_idx = coarse[MSB_W-1:COL_BITS];
  assign bin_o   = word_i[LSB_W-1:0];

  dacdec_therm #(.N(ROWS), .IDX_W(ROW_BITS)) u_row_thm (
    .idx_i(row_idx), .thm_o(row_full_o));

  dacdec_onehot #(.N(ROWS), .IDX_W(ROW_BITS)) u_row_hot (
    .idx_i(row_idx), .hot_o(row_act_o));

  dacdec_therm #(.N(COLS), .IDX_W(COL_BITS)) u_col_thm (
    .idx_i(col_idx), .thm_o(col_thm_o));

  dacdec_cells #(.ROWS(ROWS), .COLS(COLS)) u_cells (
    .row_full_i(row_full_o), .row_act_i(row_act_o),
    .col_thm_i(col_thm_o), .cell_o(cell_o));
endmodule

// File: rtl/dacdec_pick.sv
module dacdec_pick #(
  parameter int PAT_W = 163
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic             sel_up_i,
  input  logic [PAT_W-1:0] up_pat_i,
  input  logic [PAT_W-1:0] dn_pat_i,
  output logic [PAT_W-1:0] pat_q
);
  // Two data inputs, each gated by one polarity of the decision.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_q <= '0;
    end else if (fire_i) begin
      pat_q <= ({PAT_W{sel_up_i}} & up_pat_i) | ({PAT_W{~sel_up_i}} & dn_pat_i);
    end
  end

  AST_PICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_i |=> $stable(pat_q)); // R4
  AST_PICK_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && sel_up_i) |=> (pat_q == $past(up_pat_i))); // R3
  AST_PICK_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !sel_up_i) |=> (pat_q == $past(dn_pat_i))); // R3
endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder
  import dacdec_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int LSB_W  = DEF_LSB_W,
  parameter int ROWS   = DEF_ROWS,
  parameter int COLS   = DEF_COLS,
  localparam int CELLS = ROWS * COLS,
  localparam int PAT_W = ROWS + ROWS + COLS + CELLS + LSB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cand_up,
  input  logic [WORD_W-1:0] cand_dn,
  input  logic              cand_ld,
  input  logic              cmp_fire,
  input  logic              cmp_up,
  output logic [ROWS-1:0]   row_full,
  output logic [ROWS-1:0]   row_act,
  output logic [COLS-1:0]   col_sel,
  output logic [CELLS-1:0]  cell_en,
  output logic [LSB_W-1:0]  bin_sel
);
  logic [WORD_W-1:0] up_q, dn_q;
  logic [WORD_W-1:0] held [2];
  logic [PAT_W-1:0]  pat  [2];
  logic [PAT_W-1:0]  pat_q;

  dacdec_hold #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .ld_i(cand_ld),
    .up_i(cand_up), .dn_i(cand_dn), .up_q(up_q), .dn_q(dn_q));

  assign held[0] = dn_q;
  assign held[1] = up_q;

  for (genvar k = 0; k < 2; k++) begin : g_cand
    logic [ROWS-1:0]  rf, ra;
    logic [COLS-1:0]  ct;
    logic [CELLS-1:0] ce;
    logic [LSB_W-1:0] bn;

    dacdec_path #(.WORD_W(WORD_W), .LSB_W(LSB_W), .ROWS(ROWS), .COLS(COLS)) u_path (
      .word_i(held[k]), .row_full_o(rf), .row_act_o(ra),
      .col_thm_o(ct), .cell_o(ce), .bin_o(bn));

    assign pat[k] = {rf, ra, ct, ce, bn};
  end

  dacdec_pick #(.PAT_W(PAT_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .fire_i(cmp_fire), .sel_up_i(cmp_up),
    .up_pat_i(pat[1]), .dn_pat_i(pat[0]), .pat_q(pat_q));

  assign {row_full, row_act, col_sel, cell_en, bin_sel} = pat_q;

  AST_ROW_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (row_full & row_act) == '0); // R7
  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_act)); // R7
  AST_CELL_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cell_en) == $countones(row_full) * COLS + $countones(col_sel)); // R8
  AST_CELL_THERM: assert property (@(posedge clk) disable iff (!rst_n)
    ((cell_en + CELLS'(1)) & cell_en) == '0); // R9
  AST_BIN_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> (bin_sel == (($past(cmp_up)) ? $past(up_q[LSB_W-1:0])
                                             : $past(dn_q[LSB_W-1:0])))); // R5
endmodule

// File: tb/seg_dac_decoder_bench.sv
`timescale 1ns/1ps
module seg_dac_decoder_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [9:0]   cand_up = '0, cand_dn = '0;
  logic         cand_ld = 1'b0, cmp_fire = 1'b0, cmp_up = 1'b0;
  logic [7:0]   row_full, row_act;
  logic [15:0]  col_sel;
  logic [127:0] cell_en;
  logic [2:0]   bin_sel;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  seg_dac_decoder u_seg_dac_decoder (
    .clk(clk), .rst_n(rst_n), .cand_up(cand_up), .cand_dn(cand_dn),
    .cand_ld(cand_ld), .cmp_fire(cmp_fire), .cmp_up(cmp_up),
    .row_full(row_full), .row_act(row_act), .col_sel(col_sel),
    .cell_en(cell_en), .bin_sel(bin_sel));

  // {up word, down word, decision}
  localparam logic [20:0] VEC [16] = '{
    {10'd0,    10'd1023, 1'b1}, {10'd0,    10'd1023, 1'b0},
    {10'd127,  10'd128,  1'b1}, {10'd127,  10'd128,  1'b0},
    {10'd120,  10'd135,  1'b0}, {10'd895,  10'd896,  1'b1},
    {10'd895,  10'd896,  1'b0}, {10'd7,    10'd8,    1'b0},
    {10'd511,  10'd512,  1'b1}, {10'd511,  10'd512,  1'b0},
    {10'd1016, 10'd3,    1'b1}, {10'd341,  10'd682,  1'b0},
    {10'd682,  10'd341,  1'b0}, {10'd255,  10'd256,  1'b1},
    {10'd1023, 10'd0,    1'b1}, {10'd64,   10'd1000, 1'b0}
  };

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_code(input logic [9:0] code);
    logic [6:0] v;
    v = code[9:3];
    chk("R8 cell_en",  cell_en,  (128'd1 << v) - 128'd1);
    chk("R6 col_sel",  {112'd0, col_sel},  {112'd0, (16'd1 << v[3:0]) - 16'd1});
    chk("R7 row_full", {120'd0, row_full}, {120'd0, (8'd1 << v[6:4]) - 8'd1});
    chk("R7 row_act",  {120'd0, row_act},  {120'd0, 8'd1 << v[6:4]});
    chk("R5 bin_sel",  {125'd0, bin_sel},  {125'd0, code[2:0]});
  endtask

  task automatic apply(input logic [9:0] up, input logic [9:0] dn, input logic pick);
    cand_up = up; cand_dn = dn; cand_ld = 1'b1;
    @(negedge clk);
    cand_ld = 1'b0; cmp_fire = 1'b1; cmp_up = pick;
    @(negedge clk);
    cmp_fire = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    logic [127:0] prev_cell;
    logic [6:0]   prev_v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 cell_en", cell_en, '0);
    chk("R1 rows",    {112'd0, row_full, row_act}, '0);
    chk("R1 col/bin", {109'd0, col_sel, bin_sel},  '0);

    // R3: table of candidate pairs, decision picks the expected word
    for (int i = 0; i < 16; i++) begin
      apply(VEC[i][20:11], VEC[i][10:1], VEC[i][0]);
      check_code(VEC[i][0] ? VEC[i][20:11] : VEC[i][10:1]);
    end

    // Full sweep, both polarities, monotonic step check (R9)
    apply(10'd1023, 10'd0, 1'b0);
    prev_cell = cell_en;
    prev_v    = 7'd0;
    for (int code = 0; code < 1024; code++) begin
      logic [9:0] cw;
      cw = 10'(code);
      if (cw[0]) apply(cw, ~cw, 1'b1);
      else       apply(~cw, cw, 1'b0);
      check_code(cw);
      chk("R9 none off", prev_cell & ~cell_en, '0);
      chk("R9 one on", 128'($countones(cell_en & ~prev_cell)),
          (cw[9:3] != prev_v) ? 128'd1 : 128'd0);
      prev_cell = cell_en;
      prev_v    = cw[9:3];
    end

    // R2: candidates change with the load strobe low
    apply(10'h2A5, 10'h0F0, 1'b1);
    check_code(10'h2A5);
    cand_up = 10'h3FF; cand_dn = 10'h000;
    @(negedge clk);
    cmp_fire = 1'b1; cmp_up = 1'b1;
    @(negedge clk);
    cmp_fire = 1'b0;
    chk("R2 up ignored", cell_en, (128'd1 << 7'(10'h2A5 >> 3)) - 128'd1);
    cmp_fire = 1'b1; cmp_up = 1'b0;
    @(negedge clk);
    cmp_fire = 1'b0;
    chk("R2 dn ignored", cell_en, (128'd1 << 7'(10'h0F0 >> 3)) - 128'd1);

    // R4: new load without a comparator event leaves outputs alone
    cand_up = 10'h1C9; cand_dn = 10'h005; cand_ld = 1'b1;
    @(negedge clk);
    cand_ld = 1'b0;
    repeat (3) @(negedge clk);
    check_code(10'h0F0);
    cmp_fire = 1'b1; cmp_up = 1'b1;
    @(negedge clk);
    cmp_fire = 1'b0;
    check_code(10'h1C9); // R3 after a late fire

    finish_run();
  end
endmodule